// File: doc/BRIEF.md
# Compact 16-bit Pipelined Processor Core

This block is a small 16-bit processor core with a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Each cycle it fetches one 16-bit instruction from an external instruction memory through a 13-bit word address. It decodes a 3-bit opcode into arithmetic, branch, jump, load, store, no-op and halt operations and retires results into a sixteen-entry register file. Data memory is also external, word-addressed with 13 bits and read combinationally. The core drives the address and the read and write strobes and samples the read data at the end of the memory stage.

Loads and stores carry a 13-bit absolute address. A load always lands in register 7, and a store always takes its data from register 8. Branches compare two low registers and move the PC by a 6-bit magnitude, forwards or backwards, depending on a direction bit. The hardware has no hazard interlock and no forwarding. Software keeps two unrelated instructions between a producer and any consumer. Branches and jumps resolve in execute and discard the two younger instructions already in the pipeline. A halt discards its younger instructions too and freezes the PC. The writeback port shows every register update and serves as the core's trace.

Top module: `cpu16_core`

## Requirements
- R1: Opcode 0 (bits 15:13) is arithmetic, with destination in bits 12:9, first source in bits 8:5, second source in bits 4:2 and operation in bits 1:0, where 0 adds, 1 subtracts (first minus second), 2 is bitwise AND and 3 is bitwise OR, all modulo 2^16.
- R2: The second arithmetic source field is 3 bits wide and selects only registers 0 to 7, while destination and first source reach all 16 registers.
- R3: Register 0 always reads as zero; a write aimed at it is dropped and does not appear on the writeback port.
- R4: Opcode 2 loads the word at the 13-bit address in bits 12:0 into register 7, and opcode 3 writes register 8 to that address; no cycle asserts read and write strobes together.
- R5: Opcode 6 (branch if equal) and opcode 7 (branch if not equal) compare the registers named by bits 12:10 and 9:7; when taken, the next PC is PC+1+offset if bit 6 is 0 and PC+1-offset if bit 6 is 1, with offset in bits 5:0.
- R6: Opcode 1 sets the PC to the 13-bit absolute address in bits 12:0.
- R7: The two instructions that follow a taken branch or a jump in memory never change a register or memory.
- R8: Opcode 5 halts: the instructions after it never change a register or memory, the PC stops, and `halted` rises when the halt reaches writeback and stays high until reset. Opcode 4 changes nothing.
- R9: A synchronous active-low reset sets the PC to 0, empties the pipeline, clears all registers to zero and clears `halted`. The PC then counts up from 0.
- R10: A register value is visible to an instruction placed three positions after its producer (two instructions in between).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 13 | Instruction fetch word address (the PC) |
| imem_rdata | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 13 | Data memory word address |
| dmem_re | output | 1 | Data memory read strobe (load in memory stage) |
| dmem_we | output | 1 | Data memory write strobe (store in memory stage) |
| dmem_wdata | output | 16 | Store data |
| dmem_rdata | input | 16 | Data word at `dmem_addr`, combinational |
| wb_valid | output | 1 | A register is written this cycle |
| wb_reg | output | 4 | Register index being written |
| wb_data | output | 16 | Value being written |
| halted | output | 1 | Halt has reached writeback |

## Verification
Four programs run against an instruction-level model in the bench, and every register write and store is compared as it happens. The arithmetic program uses values near the 16-bit limit and the top data address. It separates the four ALU operations, shows that the 3-bit second-source field cannot reach register 13, and shows that writes to register 0 are dropped. The branch program runs a backward loop, takes a forward branch over writers, and falls through both branch types. This separates direction and offset handling from the equal and not-equal sense. The jump program places writers, a halt and a store directly behind a jump, a taken branch and a final halt. Any leak through the flush shows up as an unexpected event, and a reset in the middle of a run shows the pipeline restarting cleanly.

// File: rtl/cpu16_pkg.sv
// cpu16_pkg: shared constants, opcode and ALU encodings, control words.
// Assumes a fixed 16-bit instruction with a 3-bit opcode in bits 15:13.
package cpu16_pkg;

    localparam int XLEN  = 16;          // data path width
    localparam int AW    = 13;          // instruction and data word address width
    localparam int NREG  = 16;          // register file depth
    localparam int RIW   = $clog2(NREG);
    localparam int OFFW  = 6;           // branch offset magnitude width

    localparam logic [RIW-1:0] LOAD_DST  = RIW'(7);  // receives loaded data
    localparam logic [RIW-1:0] STORE_SRC = RIW'(8);  // supplies stored data

    typedef enum logic [2:0] {
        OPC_ARITH = 3'd0,
        OPC_JUMP  = 3'd1,
        OPC_LOAD  = 3'd2,
        OPC_STORE = 3'd3,
        OPC_NOP   = 3'd4,
        OPC_HALT  = 3'd5,
        OPC_BREQ  = 3'd6,
        OPC_BRNE  = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    // Full 11-bit decode word, most significant member first.
    typedef struct packed {
        logic jump;
        logic beq;
        logic dread;
        logic dwrite;
        logic dsel;      // store data comes from the fixed source register
        logic rwsel;     // destination forced to the fixed load register
        logic bneq;
        logic rwrite;
        logic pcwrite;   // clear only for halt
        logic branch;
        logic abssel;    // next PC from the absolute address field
    } ctl_word_t;

    // Subset of the decode word that travels down the pipeline.
    typedef struct packed {
        logic jump;
        logic branch;
        logic beq;
        logic bneq;
        logic abssel;
        logic dread;
        logic dwrite;
        logic rwrite;
        logic halt;
    } ex_ctl_t;

    function automatic ctl_word_t ctl_of(input opcode_e op);
        case (op)
            OPC_ARITH: return ctl_word_t'(11'b000_0000_1100);
            OPC_JUMP:  return ctl_word_t'(11'b100_0000_0101);
            OPC_LOAD:  return ctl_word_t'(11'b001_0010_1100);
            OPC_STORE: return ctl_word_t'(11'b000_1100_0100);
            OPC_NOP:   return ctl_word_t'(11'b000_0000_0100);
            OPC_HALT:  return ctl_word_t'(11'b000_0000_0000);
            OPC_BREQ:  return ctl_word_t'(11'b010_0000_0110);
            default:   return ctl_word_t'(11'b000_0001_0110);
        endcase
    endfunction

endpackage

// File: rtl/cpu16_decode.sv
// cpu16_decode: splits an instruction word into register indices, fields
// and the pipeline control subset. Purely combinational.
// Assumes the field layout fixed in cpu16_pkg; the low source field of the
// arithmetic form and both branch compare fields are 3 bits (registers 0-7).
module cpu16_decode
    import cpu16_pkg::*;
(
    input  logic [XLEN-1:0] ir,
    output ex_ctl_t         ctl,
    output logic [RIW-1:0]  ra_idx,
    output logic [RIW-1:0]  rb_idx,
    output logic [RIW-1:0]  rd_idx,
    output alu_op_e         alu_op,
    output logic [AW-1:0]   abs_addr,
    output logic            br_back,
    output logic [OFFW-1:0] br_off
);

    ctl_word_t cw;

    // Field extraction and register index selection.
    always_comb begin
        cw       = ctl_of(opcode_e'(ir[15:13]));
        ctl      = '{jump: cw.jump, branch: cw.branch, beq: cw.beq,
                     bneq: cw.bneq, abssel: cw.abssel, dread: cw.dread,
                     dwrite: cw.dwrite, rwrite: cw.rwrite,
                     halt: ~cw.pcwrite};
        if (cw.dsel)
            ra_idx = STORE_SRC;
        else if (cw.branch)
            ra_idx = {1'b0, ir[12:10]};
        else
            ra_idx = ir[8:5];
        rb_idx   = cw.branch ? {1'b0, ir[9:7]} : {1'b0, ir[4:2]};
        rd_idx   = cw.rwsel ? LOAD_DST : ir[12:9];
        alu_op   = alu_op_e'(ir[1:0]);
        abs_addr = ir[AW-1:0];
        br_back  = ir[6];
        br_off   = ir[OFFW-1:0];
    end

endmodule

// File: rtl/cpu16_regfile.sv
// cpu16_regfile: register file with two read ports and one write port.
// Entry 0 is hard zero. A write is bypassed to a read of the same index in
// the same cycle, so a value is visible the cycle it is written.
module cpu16_regfile #(
    parameter int W = 16,
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  ra_data,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [N];

    // Storage update; reset clears every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // Read with write-before-read bypass and hard zero at index 0.
    always_comb begin
        ra_data = (we && wa == ra_idx) ? wd : regs[ra_idx];
        rb_data = (we && wa == rb_idx) ? wd : regs[rb_idx];
        if (ra_idx == '0) ra_data = '0;
        if (rb_idx == '0) rb_data = '0;
    end

endmodule

// File: rtl/cpu16_alu.sv
// cpu16_alu: two-operand add, subtract, AND, OR; results wrap at W bits.
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);

    // Operation select.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            default: y = a | b;
        endcase
    end

endmodule

// File: rtl/cpu16_core.sv
// cpu16_core: five-stage in-order 16-bit core (fetch, decode, execute,
// memory, writeback). Branches and jumps resolve in execute and squash the
// two younger stages. A halt in execute squashes them too and stops fetch.
// Assumes software spacing for all data hazards: no interlock, no forwarding.
// Both memories are external; data reads are combinational.
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [AW-1:0]   imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [AW-1:0]   dmem_addr,
    output logic            dmem_re,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            wb_valid,
    output logic [RIW-1:0]  wb_reg,
    output logic [XLEN-1:0] wb_data,
    output logic            halted
);

    // ---- fetch state ----
    logic [AW-1:0]   pc;
    logic            stopped;
    // ---- fetch/decode ----
    logic            fd_v;
    logic [AW-1:0]   fd_pc;
    logic [XLEN-1:0] fd_ir;
    // ---- decode outputs ----
    ex_ctl_t         id_ctl;
    logic [RIW-1:0]  id_ra, id_rb, id_rd;
    alu_op_e         id_op;
    logic [AW-1:0]   id_addr;
    logic            id_back;
    logic [OFFW-1:0] id_off;
    logic [XLEN-1:0] id_a, id_b;
    // ---- decode/execute ----
    logic            de_v;
    ex_ctl_t         de_c;
    logic [AW-1:0]   de_pc, de_addr;
    logic [XLEN-1:0] de_a, de_b;
    logic [RIW-1:0]  de_rd;
    alu_op_e         de_op;
    logic            de_back;
    logic [OFFW-1:0] de_off;
    // ---- execute ----
    logic [XLEN-1:0] ex_res;
    logic            ex_take, ex_redirect, ex_halt;
    logic [AW-1:0]   ex_seq, ex_brtgt, ex_target;
    // ---- execute/memory ----
    logic            em_v, em_dread, em_dwrite, em_rwrite, em_halt;
    logic [XLEN-1:0] em_res, em_sdata;
    logic [RIW-1:0]  em_rd;
    logic [AW-1:0]   em_addr;
    // ---- memory/writeback ----
    logic            mw_v, mw_rwrite, mw_halt;
    logic [RIW-1:0]  mw_rd;
    logic [XLEN-1:0] mw_data;
    logic            halted_q;

    // PC: restart at 0, freeze on halt, redirect on taken control flow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= '0;
            stopped <= 1'b0;
        end else if (ex_halt) begin
            stopped <= 1'b1;
        end else if (ex_redirect) begin
            pc <= ex_target;
        end else if (!stopped) begin
            pc <= pc + AW'(1);
        end
    end

    assign imem_addr = pc;

    // Fetch/decode register; squashed by redirect, halt or a stopped PC.
    always_ff @(posedge clk) begin
        if (!rst_n || ex_redirect || ex_halt || stopped) begin
            fd_v <= 1'b0;
        end else begin
            fd_v  <= 1'b1;
            fd_pc <= pc;
            fd_ir <= imem_rdata;
        end
    end

    cpu16_decode u_dec (
        .ir       (fd_ir),
        .ctl      (id_ctl),
        .ra_idx   (id_ra),
        .rb_idx   (id_rb),
        .rd_idx   (id_rd),
        .alu_op   (id_op),
        .abs_addr (id_addr),
        .br_back  (id_back),
        .br_off   (id_off)
    );

    cpu16_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (id_ra),
        .rb_idx  (id_rb),
        .ra_data (id_a),
        .rb_data (id_b),
        .we      (wb_valid),
        .wa      (wb_reg),
        .wd      (wb_data)
    );

    // Decode/execute register; the decode slot is squashed on redirect or halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_v <= 1'b0;
        end else begin
            de_v    <= fd_v && !ex_redirect && !ex_halt;
            de_c    <= id_ctl;
            de_pc   <= fd_pc;
            de_addr <= id_addr;
            de_a    <= id_a;
            de_b    <= id_b;
            de_rd   <= id_rd;
            de_op   <= id_op;
            de_back <= id_back;
            de_off  <= id_off;
        end
    end

    cpu16_alu #(.W(XLEN)) u_alu (
        .op (de_op),
        .a  (de_a),
        .b  (de_b),
        .y  (ex_res)
    );

    // Branch decision and next-PC computation.
    always_comb begin
        ex_take     = de_c.branch &&
                      ((de_c.beq && de_a == de_b) || (de_c.bneq && de_a != de_b));
        ex_redirect = de_v && (de_c.jump || ex_take);
        ex_halt     = de_v && de_c.halt;
        ex_seq      = de_pc + AW'(1);
        ex_brtgt    = de_back ? ex_seq - AW'(de_off) : ex_seq + AW'(de_off);
        ex_target   = de_c.abssel ? de_addr : ex_brtgt;
    end

    // Execute/memory register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            em_v <= 1'b0;
        end else begin
            em_v      <= de_v;
            em_dread  <= de_c.dread;
            em_dwrite <= de_c.dwrite;
            em_rwrite <= de_c.rwrite;
            em_halt   <= de_c.halt;
            em_res    <= ex_res;
            em_sdata  <= de_a;
            em_rd     <= de_rd;
            em_addr   <= de_addr;
        end
    end

    assign dmem_addr  = em_addr;
    assign dmem_re    = em_v && em_dread;
    assign dmem_we    = em_v && em_dwrite;
    assign dmem_wdata = em_sdata;

    // Memory/writeback register; selects load data or the ALU result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_v <= 1'b0;
        end else begin
            mw_v      <= em_v;
            mw_rwrite <= em_rwrite;
            mw_halt   <= em_halt;
            mw_rd     <= em_rd;
            mw_data   <= em_dread ? dmem_rdata : em_res;
        end
    end

    // Sticky halt indication once halt has passed writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) halted_q <= 1'b0;
        else if (mw_v && mw_halt) halted_q <= 1'b1;
    end

    assign wb_valid = mw_v && mw_rwrite && (mw_rd != '0);
    assign wb_reg   = mw_rd;
    assign wb_data  = mw_data;
    assign halted   = halted_q || (mw_v && mw_halt);

endmodule

// File: rtl/cpu16_core_chk.sv
// cpu16_core_chk: port-level properties of the core, bound to every instance.
module cpu16_core_chk
    import cpu16_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  imem_addr,
    input logic           dmem_re,
    input logic           dmem_we,
    input logic           wb_valid,
    input logic [RIW-1:0] wb_reg,
    input logic           halted
);

    // R3
    wb_zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_reg != '0);

    // R4
    mem_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_re && dmem_we));

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8
    halt_pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(imem_addr));

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!wb_valid && !dmem_we && !dmem_re));

endmodule

bind cpu16_core cpu16_core_chk i_core_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .dmem_re   (dmem_re),
    .dmem_we   (dmem_we),
    .wb_valid  (wb_valid),
    .wb_reg    (wb_reg),
    .halted    (halted)
);

// File: tb/test_cpu16_core.sv
// test_cpu16_core: runs small programs and compares every register write and
// every store with an instruction-level model, on each falling clock edge.
module test_cpu16_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] imem_addr;
    logic [15:0] imem_rdata = '0;
    logic [12:0] dmem_addr;
    logic        dmem_re, dmem_we;
    logic [15:0] dmem_wdata;
    logic [15:0] dmem_rdata = '0;
    logic        wb_valid;
    logic [3:0]  wb_reg;
    logic [15:0] wb_data;
    logic        halted;

    always #2 clk = ~clk;   // 250 MHz

    cpu16_core i_cpu16_core (
        .clk (clk), .rst_n (rst_n),
        .imem_addr (imem_addr), .imem_rdata (imem_rdata),
        .dmem_addr (dmem_addr), .dmem_re (dmem_re), .dmem_we (dmem_we),
        .dmem_wdata (dmem_wdata), .dmem_rdata (dmem_rdata),
        .wb_valid (wb_valid), .wb_reg (wb_reg), .wb_data (wb_data),
        .halted (halted)
    );

    localparam logic [15:0] W_NOP = 16'h8000;  // opcode 4
    localparam logic [15:0] W_HLT = 16'hA000;  // opcode 5

    logic [15:0] imem [int];
    logic [15:0] dmem [int];
    logic [19:0] exp_wb [$];     // {reg, data}
    logic [28:0] exp_st [$];     // {addr, data}
    logic [19:0] e_wb;
    logic [28:0] e_st;
    int          n_chk = 0;
    int          n_err = 0;
    bit          cmp_en = 1'b0;
    string       cur_req = "R9";
    int          at;

    function automatic logic [15:0] rd_i(input int a);
        return imem.exists(a) ? imem[a] : W_HLT;
    endfunction

    function automatic logic [15:0] rd_d(input int a);
        return dmem.exists(a) ? dmem[a] : 16'h0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory responder and per-cycle event comparison.
    always @(negedge clk) begin
        imem_rdata = rd_i(int'(imem_addr));
        dmem_rdata = rd_d(int'(dmem_addr));
        if (cmp_en) begin
            if (wb_valid) begin
                if (exp_wb.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected register write",
                        {12'd0, wb_reg, wb_data}, 32'd0);
                end else begin
                    e_wb = exp_wb.pop_front();
                    chk({wb_reg, wb_data} == e_wb, cur_req, "register write",
                        {12'd0, wb_reg, wb_data}, {12'd0, e_wb});
                end
            end
            if (dmem_we) begin
                if (exp_st.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected store",
                        {3'd0, dmem_addr, dmem_wdata}, 32'd0);
                end else begin
                    e_st = exp_st.pop_front();
                    chk({dmem_addr, dmem_wdata} == e_st, cur_req, "store",
                        {3'd0, dmem_addr, dmem_wdata}, {3'd0, e_st});
                end
            end
        end
        if (rst_n && dmem_we) dmem[int'(dmem_addr)] = dmem_wdata;
    end

    // ---- instruction encoders ----
    function automatic logic [15:0] e_alu(input int rd, input int s1, input int s2, input int op);
        return {3'd0, 4'(rd), 4'(s1), 3'(s2), 2'(op)};
    endfunction
    function automatic logic [15:0] e_br(input bit ne, input int c1, input int c2,
                                         input bit back, input int off);
        return {(ne ? 3'd7 : 3'd6), 3'(c1), 3'(c2), back, 6'(off)};
    endfunction
    function automatic logic [15:0] e_abs(input logic [2:0] opc, input int a);
        return {opc, 13'(a)};
    endfunction

    task automatic put(input logic [15:0] w);
        imem[at] = w;
        at++;
    endtask
    task automatic ins(input logic [15:0] w);   // instruction plus spacing
        put(w); put(W_NOP); put(W_NOP);
    endtask

    // Instruction-level model producing the expected event streams.
    task automatic run_model();
        logic [15:0] r [16];
        logic [15:0] mm [int];
        logic [12:0] pc;
        logic [15:0] w, a, b, v;
        exp_wb.delete();
        exp_st.delete();
        mm = dmem;
        for (int i = 0; i < 16; i++) r[i] = '0;
        pc = '0;
        for (int s = 0; s < 20000; s++) begin
            w = rd_i(int'(pc));
            if (w[15:13] == 3'd5) break;
            case (w[15:13])
                3'd0: begin
                    a = r[w[8:5]];
                    b = r[{1'b0, w[4:2]}];
                    case (w[1:0])
                        2'd0: v = a + b;
                        2'd1: v = a - b;
                        2'd2: v = a & b;
                        default: v = a | b;
                    endcase
                    if (w[12:9] != 4'd0) begin
                        r[w[12:9]] = v;
                        exp_wb.push_back({w[12:9], v});
                    end
                    pc = pc + 13'd1;
                end
                3'd1: pc = w[12:0];
                3'd2: begin
                    v = mm.exists(int'(w[12:0])) ? mm[int'(w[12:0])] : 16'h0;
                    r[7] = v;
                    exp_wb.push_back({4'd7, v});
                    pc = pc + 13'd1;
                end
                3'd3: begin
                    mm[int'(w[12:0])] = r[8];
                    exp_st.push_back({w[12:0], r[8]});
                    pc = pc + 13'd1;
                end
                3'd6, 3'd7: begin
                    a = r[{1'b0, w[12:10]}];
                    b = r[{1'b0, w[9:7]}];
                    if ((w[13] == 1'b0) == (a == b))
                        pc = w[6] ? pc + 13'd1 - 13'(w[5:0]) : pc + 13'd1 + 13'(w[5:0]);
                    else
                        pc = pc + 13'd1;
                end
                default: pc = pc + 13'd1;
            endcase
        end
    endtask

    // Reset sequence with checks of the reset state (R9).
    task automatic do_reset();
        cmp_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(imem_addr == 13'd0, "R9", "PC in reset", 32'(imem_addr), 32'd0);
        chk(!wb_valid && !dmem_we && !dmem_re, "R9", "no activity in reset",
            {29'd0, wb_valid, dmem_we, dmem_re}, 32'd0);
        chk(!halted, "R9", "halted cleared", 32'(halted), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(imem_addr == 13'd1, "R9", "PC counts after reset", 32'(imem_addr), 32'd1);
    endtask

    // Run the loaded program to its halt and check the halted behaviour (R8).
    task automatic run_prog(input string req);
        logic [12:0] pc_hold;
        int          guard;
        cur_req = req;
        run_model();
        do_reset();
        cmp_en = 1'b1;
        guard = 0;
        while (!halted && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        #1;
        chk(halted, "R8", "halted reached", 32'(halted), 32'd1);
        chk(exp_wb.size() == 0, req, "register writes left at halt", exp_wb.size(), 0);
        chk(exp_st.size() == 0, req, "stores left at halt", exp_st.size(), 0);
        pc_hold = imem_addr;
        repeat (6) begin
            @(negedge clk);
            chk(halted && imem_addr == pc_hold, "R8", "frozen after halt",
                {halted, 18'd0, imem_addr}, {1'b1, 18'd0, pc_hold});
        end
        cmp_en = 1'b0;
    endtask

    // R1 R2 R3 R4 R10: arithmetic, register reach, register 0, loads, stores.
    task automatic load_arith();
        imem.delete(); dmem.delete(); at = 0;
        dmem[32'h100]  = 16'h1234;
        dmem[32'h101]  = 16'h00F0;
        dmem[32'h1FFF] = 16'hFFFF;
        ins(e_abs(3'd2, 'h100)); ins(e_alu(1, 7, 0, 0));
        ins(e_abs(3'd2, 'h101)); ins(e_alu(2, 7, 0, 0));
        ins(e_abs(3'd2, 'h1FFF)); ins(e_alu(13, 7, 0, 0));
        ins(e_alu(3, 1, 2, 0));     // add
        ins(e_alu(4, 2, 1, 1));     // sub, borrow wraps
        ins(e_alu(5, 0, 1, 1));     // 0 - r1
        ins(e_alu(6, 1, 2, 2));     // and
        ins(e_alu(9, 1, 2, 3));     // or
        ins(e_alu(10, 13, 1, 0));   // wraps past 16 bits
        ins(e_alu(11, 1, 13, 0));   // field 13 truncates to r5
        ins(e_alu(0, 1, 2, 0));     // dropped
        ins(e_alu(12, 0, 1, 0));    // r0 still zero
        ins(e_alu(8, 3, 0, 0)); ins(e_abs(3'd3, 'h200));
        ins(e_alu(8, 10, 0, 0)); ins(e_abs(3'd3, 'h1FFE));
        ins(e_abs(3'd2, 'h200));
        put(W_HLT);
    endtask

    // R5 R7: backward loop, forward taken branch, two fall-throughs.
    task automatic load_branch();
        int lp, b;
        imem.delete(); dmem.delete(); at = 0;
        dmem[0] = 16'd3; dmem[1] = 16'd1; dmem[2] = 16'd5;
        ins(e_abs(3'd2, 0)); ins(e_alu(1, 7, 0, 0));
        ins(e_abs(3'd2, 1)); ins(e_alu(2, 7, 0, 0));
        ins(e_abs(3'd2, 2)); ins(e_alu(3, 7, 0, 0));
        lp = at;
        ins(e_alu(1, 1, 2, 1));
        ins(e_alu(4, 4, 2, 0));
        b = at;
        ins(e_br(1'b1, 1, 0, 1'b1, b + 1 - lp));     // loop while r1 != 0
        put(e_br(1'b0, 1, 0, 1'b0, 5));              // taken, skips 5 writers
        put(e_alu(5, 3, 0, 0)); put(e_alu(6, 3, 3, 0)); put(e_alu(9, 3, 0, 0));
        put(e_alu(11, 3, 0, 0)); put(e_alu(12, 3, 0, 0));
        put(e_br(1'b1, 2, 2, 1'b0, 3));              // equal: falls through
        put(e_alu(5, 3, 0, 0)); put(W_NOP); put(W_NOP);
        put(e_br(1'b0, 1, 2, 1'b1, 2));              // unequal: falls through
        put(e_alu(6, 3, 2, 0)); put(W_NOP); put(W_NOP);
        put(W_HLT);
    endtask

    // R6 R7 R8: jumps high and back, branch over a halt, halt before writers.
    task automatic load_jump();
        imem.delete(); dmem.delete(); at = 0;
        dmem[5] = 16'h00AA;
        ins(e_abs(3'd2, 5)); ins(e_alu(1, 7, 0, 0));
        put(e_abs(3'd1, 'h1F40));
        put(e_alu(2, 1, 1, 0)); put(e_alu(3, 1, 1, 0));   // squashed
        at = 'h1F40;
        ins(e_alu(4, 1, 1, 0));
        put(e_abs(3'd1, 'h40));
        put(e_alu(5, 1, 0, 0)); put(W_NOP);                // squashed
        at = 'h40;
        put(e_br(1'b0, 0, 0, 1'b0, 3));                     // always taken
        put(W_HLT);                                         // squashed halt
        put(e_alu(6, 1, 0, 0)); put(e_alu(9, 1, 1, 0));
        ins(e_alu(9, 1, 0, 0));
        ins(e_alu(8, 1, 1, 3));
        put(W_HLT);
        put(e_alu(10, 1, 1, 0)); put(e_abs(3'd3, 'h300)); put(e_alu(11, 1, 0, 0));
    endtask

    // Global watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        load_arith();
        run_prog("R1/R2/R3/R4/R10");
        chk(rd_d('h200) == 16'h1324, "R4", "stored word at 0x200", rd_d('h200), 16'h1324);
        chk(rd_d('h1FFE) == 16'h1233, "R4", "stored word at 0x1FFE", rd_d('h1FFE), 16'h1233);

        load_branch();
        run_prog("R5/R7");

        load_jump();
        run_prog("R6/R7/R8");
        chk(!dmem.exists('h300), "R8", "store after halt absent",
            32'(dmem.exists('h300)), 32'd0);

        // R9: reset in the middle of a run, then a clean rerun.
        load_branch();
        run_model();
        do_reset();
        cur_req = "R9";
        cmp_en = 1'b1;
        repeat (20) @(negedge clk);
        cmp_en = 1'b0;
        run_prog("R9/R5");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule